// File: doc/BRIEF.md
# FSK Proximity Tag Waveform Frame Generator

This block produces the coil-loading sample stream that lets a reader-side circuit pose as a low-frequency FSK proximity tag holding a 44-bit identifier. Each sample is a single bit: 1 leaves the coil open and 0 shorts it. The block moves forward by one sample on every cycle in which `tick` is high. The clock that drives `tick` comes from the reader's field. A frame is assembled from sub-carrier groups of two kinds. A low group is six repeats of the 8-sample cycle 11000000, 48 samples in all. A high group is five repeats of the 10-sample cycle 1110000000, 50 samples in all.

A frame opens with a start marker that is not valid Manchester. The identifier follows, most significant bit first. Each bit is coded as an ordered pair of groups. Before bit 43 and before every fourth bit after it, one 8-sample filler cycle is sent. When the last group of a frame ends, the next frame starts on the very next sample.

Software writes a new identifier through a parallel port with a strobe. The value is staged and only becomes active when the next frame starts, so a frame is never transmitted with a mix of two identifiers.

The sequencer has five states. IDLE holds the coil open while `en` is low. SOF walks through the eight marker groups. FILL sends the single filler cycle. BIT_A sends the first group of a bit and BIT_B sends the second. The transitions are:
- start: IDLE to SOF, on any cycle with `en` high.
- marker_done: SOF to FILL after the eighth marker group.
- pad_done: FILL to BIT_A.
- half_done: BIT_A to BIT_B.
- next_bit: BIT_B to BIT_A, or to FILL when the next bit index is 3 modulo 4.
- wrap: BIT_B to SOF after bit 0.
- stop: any state to IDLE when `en` is low.

Top module: `fsktag_framer`

## Requirements
- R1: After reset, and on every cycle in which `en` is low, `coil_out` is 1 (open coil), whatever `tick` and `id_load` do.
- R2: The sample position moves forward by exactly one on each clock cycle with `tick` high. On a cycle with `tick` low, `coil_out` holds its value.
- R3: A low group is the 8-sample cycle 1,1,0,0,0,0,0,0 repeated six times (48 samples).
- R4: A high group is the 10-sample cycle 1,1,1,0,0,0,0,0,0,0 repeated five times (50 samples).
- R5: A frame opens with eight groups in this order: low, low, low, high, high, high, low, high (392 samples).
- R6: The identifier is sent from bit 43 down to bit 0. A 1 bit is a low group followed by a high group. A 0 bit is a high group followed by a low group.
- R7: One 8-sample filler 1,1,0,0,0,0,0,0 is sent just before each bit whose index modulo 4 is 3 (bits 43, 39, …, 3).
- R8: A frame is 4792 samples long. The next frame's first sample follows the last one with no gap.
- R9: A pulse on `id_load` stages `id_in`. A frame already in progress keeps its identifier. The staged value is used from the start of the next frame.
- R10: In the cycle after `en` rises, `coil_out` shows sample 0 of a new frame, and that frame carries the staged identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low forces the coil open and rewinds the frame |
| tick | input | 1 | Sample advance strobe derived from the reader field |
| id_load | input | 1 | Stage `id_in` as the identifier for the next frame |
| id_in | input | 44 | Identifier value, bit 43 sent first |
| coil_out | output | 1 | 1 = open coil, 0 = shorted coil |

## Verification
A phase or repeat counter that has gone out of step shows up within one group. The bad sample appears inside 8 to 10 ticks, because a low cycle ends up with three high samples or a high cycle with two. A bit index or state that is wrong keeps the group lengths intact but swaps a low/high pair, or drops or adds a filler. The first place this can be seen is the affected bit's slot, up to about a hundred ticks later. A wrong active identifier, or an early commit, alters the first bit that differs between the old and new values. For this reason the bench compares every sample of whole frames, across wraps and across mid-frame loads.

// File: rtl/fsktag_pkg.sv
package fsktag_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SOF,
        ST_FILL,
        ST_BIT_A,
        ST_BIT_B
    } seq_state_t;

    typedef enum logic [1:0] {
        GRP_LO,
        GRP_HI,
        GRP_PAD
    } grp_kind_t;

    localparam int LO_PERIOD = 8;
    localparam int LO_HIGH   = 2;
    localparam int LO_REPS   = 6;
    localparam int HI_PERIOD = 10;
    localparam int HI_HIGH   = 3;
    localparam int HI_REPS   = 5;
    localparam int PAD_REPS  = 1;

    localparam int SOF_LEN = 8;
    // bit i set: marker group i is a high group
    localparam logic [SOF_LEN-1:0] SOF_HI_MASK = 8'b1011_1000;

    localparam int PHASE_W = $clog2(HI_PERIOD);
    localparam int REP_W   = $clog2(LO_REPS);
    localparam int SOF_W   = $clog2(SOF_LEN);

endpackage

// File: rtl/fsktag_shaper.sv
module fsktag_shaper
    import fsktag_pkg::*;
(
    input  grp_kind_t          kind,
    input  logic [PHASE_W-1:0] phase,
    input  logic [REP_W-1:0]   rep,
    output logic               level,
    output logic               cyc_last,
    output logic               grp_last
);

    int period_n;
    int high_n;
    int reps_n;

    always_comb begin
        case (kind)
            GRP_HI: begin
                period_n = HI_PERIOD;
                high_n   = HI_HIGH;
                reps_n   = HI_REPS;
            end
            GRP_PAD: begin
                period_n = LO_PERIOD;
                high_n   = LO_HIGH;
                reps_n   = PAD_REPS;
            end
            default: begin
                period_n = LO_PERIOD;
                high_n   = LO_HIGH;
                reps_n   = LO_REPS;
            end
        endcase
        level    = int'(phase) < high_n;
        cyc_last = int'(phase) == period_n - 1;
        grp_last = cyc_last && (int'(rep) == reps_n - 1);
    end

endmodule

// File: rtl/fsktag_idbuf.sv
module fsktag_idbuf #(
    parameter int ID_W = 44
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            id_load,
    input  logic [ID_W-1:0] id_in,
    input  logic            commit,
    output logic [ID_W-1:0] act_id
);

    logic [ID_W-1:0] staged_q;
    logic [ID_W-1:0] act_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged_q <= '0;
            act_q    <= '0;
        end else begin
            if (id_load) staged_q <= id_in;
            if (commit)  act_q    <= staged_q;
        end
    end

    assign act_id = act_q;

endmodule

// File: rtl/fsktag_seq.sv
module fsktag_seq
    import fsktag_pkg::*;
#(
    parameter int ID_W = 44,
    parameter int NIB  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               tick,
    input  logic [ID_W-1:0]    act_id,
    input  logic               cyc_last,
    input  logic               grp_last,
    output seq_state_t         st,
    output logic [PHASE_W-1:0] phase,
    output logic [REP_W-1:0]   rep,
    output grp_kind_t          kind,
    output logic               commit
);

    localparam int BIT_W = $clog2(ID_W);
    localparam logic [BIT_W-1:0] TOP_BIT  = BIT_W'(ID_W - 1);
    localparam logic [SOF_W-1:0] SOF_LAST = SOF_W'(SOF_LEN - 1);

    seq_state_t         st_q, st_d;
    logic [PHASE_W-1:0] phase_q, phase_d;
    logic [REP_W-1:0]   rep_q, rep_d;
    logic [SOF_W-1:0]   sof_q, sof_d;
    logic [BIT_W-1:0]   bit_q, bit_d;

    function automatic logic pad_before(input logic [BIT_W-1:0] b);
        return (int'(b) % NIB) == NIB - 1;
    endfunction

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            phase_q <= '0;
            rep_q   <= '0;
            sof_q   <= '0;
            bit_q   <= TOP_BIT;
        end else begin
            st_q    <= st_d;
            phase_q <= phase_d;
            rep_q   <= rep_d;
            sof_q   <= sof_d;
            bit_q   <= bit_d;
        end
    end

    // transitions
    always_comb begin
        st_d    = st_q;
        phase_d = phase_q;
        rep_d   = rep_q;
        sof_d   = sof_q;
        bit_d   = bit_q;
        commit  = 1'b0;
        if (!en) begin
            st_d    = ST_IDLE;
            phase_d = '0;
            rep_d   = '0;
            sof_d   = '0;
            bit_d   = TOP_BIT;
        end else if (st_q == ST_IDLE) begin
            st_d   = ST_SOF;
            commit = 1'b1;
        end else if (tick) begin
            if (!grp_last) begin
                if (cyc_last) begin
                    phase_d = '0;
                    rep_d   = rep_q + REP_W'(1);
                end else begin
                    phase_d = phase_q + PHASE_W'(1);
                end
            end else begin
                phase_d = '0;
                rep_d   = '0;
                unique case (st_q)
                    ST_SOF: begin
                        if (sof_q == SOF_LAST) begin
                            bit_d = TOP_BIT;
                            st_d  = pad_before(TOP_BIT) ? ST_FILL : ST_BIT_A;
                        end else begin
                            sof_d = sof_q + SOF_W'(1);
                        end
                    end
                    ST_FILL:  st_d = ST_BIT_A;
                    ST_BIT_A: st_d = ST_BIT_B;
                    ST_BIT_B: begin
                        if (bit_q == '0) begin
                            st_d   = ST_SOF;
                            sof_d  = '0;
                            bit_d  = TOP_BIT;
                            commit = 1'b1;
                        end else begin
                            bit_d = bit_q - BIT_W'(1);
                            st_d  = pad_before(bit_q - BIT_W'(1)) ? ST_FILL : ST_BIT_A;
                        end
                    end
                    default: st_d = ST_IDLE;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            ST_SOF:   kind = SOF_HI_MASK[sof_q] ? GRP_HI : GRP_LO;
            ST_FILL:  kind = GRP_PAD;
            ST_BIT_A: kind = act_id[bit_q] ? GRP_LO : GRP_HI;
            ST_BIT_B: kind = act_id[bit_q] ? GRP_HI : GRP_LO;
            default:  kind = GRP_LO;
        endcase
    end

    assign st    = st_q;
    assign phase = phase_q;
    assign rep   = rep_q;

endmodule

// File: rtl/fsktag_framer.sv
module fsktag_framer
    import fsktag_pkg::*;
#(
    parameter int ID_W = 44,
    parameter int NIB  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            tick,
    input  logic            id_load,
    input  logic [ID_W-1:0] id_in,
    output logic            coil_out
);

    seq_state_t         seq_st;
    logic [PHASE_W-1:0] seq_phase;
    logic [REP_W-1:0]   seq_rep;
    grp_kind_t          seq_kind;
    logic               seq_commit;
    logic [ID_W-1:0]    act_id;
    logic               level;
    logic               cyc_last;
    logic               grp_last;

    fsktag_idbuf #(.ID_W(ID_W)) u_idbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .id_load (id_load),
        .id_in   (id_in),
        .commit  (seq_commit),
        .act_id  (act_id)
    );

    fsktag_seq #(.ID_W(ID_W), .NIB(NIB)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .tick     (tick),
        .act_id   (act_id),
        .cyc_last (cyc_last),
        .grp_last (grp_last),
        .st       (seq_st),
        .phase    (seq_phase),
        .rep      (seq_rep),
        .kind     (seq_kind),
        .commit   (seq_commit)
    );

    fsktag_shaper u_shaper (
        .kind     (seq_kind),
        .phase    (seq_phase),
        .rep      (seq_rep),
        .level    (level),
        .cyc_last (cyc_last),
        .grp_last (grp_last)
    );

    assign coil_out = (!en || seq_st == ST_IDLE) ? 1'b1 : level;

endmodule

// File: rtl/fsktag_checker.sv
module fsktag_checker
    import fsktag_pkg::*;
#(
    parameter int ID_W = 44
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en,
    input logic               tick,
    input logic               coil_out,
    input seq_state_t         seq_st,
    input logic [PHASE_W-1:0] seq_phase,
    input logic [REP_W-1:0]   seq_rep,
    input logic               seq_commit,
    input logic [ID_W-1:0]    act_id
);

    a_r1_disabled_open: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> coil_out);

    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick && seq_st != ST_IDLE) |=> (!en || $stable(coil_out)));

    // R3 and R4: counters stay inside the longest cycle and group
    a_r4_counter_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(seq_phase) < HI_PERIOD) && (int'(seq_rep) < LO_REPS));

    a_r9_id_frozen_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_commit |=> $stable(act_id));

    a_r10_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (en && seq_st == ST_IDLE) |=> (seq_st == ST_SOF && seq_phase == '0 && seq_rep == '0));

endmodule

bind fsktag_framer fsktag_checker #(.ID_W(ID_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .tick       (tick),
    .coil_out   (coil_out),
    .seq_st     (seq_st),
    .seq_phase  (seq_phase),
    .seq_rep    (seq_rep),
    .seq_commit (seq_commit),
    .act_id     (act_id)
);

// File: tb/tb_fsktag_framer.sv
`timescale 1ns/1ps
module tb_fsktag_framer;

    localparam int FRAME_N = 4792;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        tick = 1'b0;
    logic        id_load = 1'b0;
    logic [43:0] id_in = '0;
    logic        coil_out;

    int n_chk = 0;
    int n_fail = 0;
    int n_fill = 0;
    logic  exp_s [FRAME_N];
    string tag_s [FRAME_N];

    always #4 clk = ~clk;

    fsktag_framer dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .tick     (tick),
        .id_load  (id_load),
        .id_in    (id_in),
        .coil_out (coil_out)
    );

    task automatic check(input logic act, input logic exp, input string req, input string ctx);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: coil_out=%0b expected=%0b at %0t", req, ctx, act, exp, $time);
        end
    endtask

    task automatic push_grp(input int period, input int high, input int reps, input string t);
        for (int r = 0; r < reps; r++)
            for (int p = 0; p < period; p++) begin
                exp_s[n_fill] = (p < high);
                tag_s[n_fill] = t;
                n_fill++;
            end
    endtask

    // expected frame from the requirements
    task automatic build(input logic [43:0] id);
        n_fill = 0;
        push_grp(8, 2, 6, "R5"); push_grp(8, 2, 6, "R5"); push_grp(8, 2, 6, "R5");
        push_grp(10, 3, 5, "R5"); push_grp(10, 3, 5, "R5"); push_grp(10, 3, 5, "R5");
        push_grp(8, 2, 6, "R5"); push_grp(10, 3, 5, "R5");
        for (int i = 43; i >= 0; i--) begin
            if (i % 4 == 3) push_grp(8, 2, 1, "R7");
            if (id[i]) begin
                push_grp(8, 2, 6, "R6 R3");
                push_grp(10, 3, 5, "R6 R4");
            end else begin
                push_grp(10, 3, 5, "R6 R4");
                push_grp(8, 2, 6, "R6 R3");
            end
        end
        if (n_fill != FRAME_N) begin
            n_chk++;
            n_fail++;
            $display("FAIL R8 model length=%0d expected=%0d", n_fill, FRAME_N);
        end
    endtask

    // checks one full frame starting at its sample 0; leaves the design at the next frame's sample 0
    task automatic check_frame(input logic [43:0] id, input bit do_load, input logic [43:0] nid,
                               input int load_at, input int hold_at, input string ftag);
        build(id);
        for (int k = 0; k < FRAME_N; k++) begin
            check(coil_out, exp_s[k], tag_s[k], (k == 0) ? ftag : "");
            if (k == hold_at)
                for (int h = 0; h < 5; h++) begin
                    @(negedge clk);
                    check(coil_out, exp_s[k], "R2", "hold");
                end
            tick = 1'b1;
            if (do_load && k == load_at) begin
                id_load = 1'b1;
                id_in   = nid;
            end
            @(negedge clk);
            tick    = 1'b0;
            id_load = 1'b0;
        end
    endtask

    task automatic t_reset(input logic [43:0] id);
        check(coil_out, 1'b1, "R1", "reset");
        id_in = id;
        id_load = 1'b1;
        @(negedge clk);
        id_load = 1'b0;
        for (int c = 0; c < 6; c++) begin
            tick = c[0];
            @(negedge clk);
            check(coil_out, 1'b1, "R1", "disabled ticks");
        end
        tick = 1'b0;
    endtask

    task automatic t_run(input logic [43:0] id);
        en = 1'b1;
        @(negedge clk);
        check_frame(id, 1'b0, '0, -1, 123, "R10 first frame");
        check_frame(id, 1'b0, '0, -1, -1, "R8 wrap");
    endtask

    task automatic t_load(input logic [43:0] a, input logic [43:0] b);
        check_frame(a, 1'b1, b, 1500, -1, "R9 old id kept");
        check_frame(b, 1'b0, '0, -1, -1, "R9 new id used");
    endtask

    task automatic t_disable(input logic [43:0] cur, input logic [43:0] nid);
        for (int k = 0; k < 700; k++) begin
            tick = 1'b1;
            @(negedge clk);
        end
        tick = 1'b0;
        en = 1'b0;
        #1 check(coil_out, 1'b1, "R1", "en dropped");
        id_in = nid;
        id_load = 1'b1;
        @(negedge clk);
        id_load = 1'b0;
        for (int c = 0; c < 8; c++) begin
            tick = 1'b1;
            @(negedge clk);
            check(coil_out, 1'b1, "R1", "disabled");
        end
        tick = 1'b0;
        en = 1'b1;
        @(negedge clk);
        check_frame(nid, 1'b1, cur, 3000, -1, "R10 restart");
        check_frame(cur, 1'b0, '0, -1, 40, "R9 after restart");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset(44'hA5C_3F01_9E72);
        t_run(44'hA5C_3F01_9E72);
        t_load(44'hA5C_3F01_9E72, 44'h000_0000_0001);
        t_disable(44'hFFF_FFFF_FFFF, 44'h000_0000_0000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired: actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule